// File: doc/BRIEF.md
# Stream-to-Memory Descriptor Writer

This block is the receive engine of a scatter-gather DMA channel. It takes a byte-wide framed data stream and a separate stream of 32-bit sideband words. It walks a linked list of descriptors in memory and spreads each incoming frame across the buffers those descriptors point to. A descriptor takes at most the length written in it, so one frame may span several descriptors. When a descriptor is finished, the block writes back its status word. That word carries the byte count, a completion flag, and start-of-frame and end-of-frame markers.

The sideband stream delivers five words per frame. The block latches them and stores them in the descriptor that receives the frame's final byte, and then it pulses a frame-completion output. Software supplies the first descriptor pointer, a tail pointer and a run enable. The engine idles after it finishes the tail descriptor. It halts if it fetches a descriptor that is already marked complete. In both cases, and whenever run is low, the data input holds back its ready.

The descriptor is a block of 32-bit words at byte offsets from its base address:
- next pointer at 0
- buffer address at 4
- control at 8, with the length in bits 22:0
- status at 12
- the five sideband words at 16, 20, 24, 28 and 32

Top module: `s2m_desc_writer`

## Requirements
- R1: `s_ready` is low while `run` is low, while `idle` is high, while `halted` is high, and during reset. After reset `halted` is 1 and `idle` is 0.
- R2: The control input always accepts words (`c_ready`=1). The last five words received, counted modulo five from reset, are written in order to byte offsets 16, 20, 24, 28 and 32 of the descriptor that ends a frame.
- R3: If a fetched descriptor already has status bit 31 set, the engine sets `halted`, writes nothing and keeps `s_ready` low. A `cur_load` pulse loads the current pointer and clears `halted` and `idle`.
- R4: Each descriptor stores min(control bits 22:0, bytes remaining in the frame). Bytes go to consecutive addresses from its buffer address, and no byte beyond that count is written.
- R5: Status bit 27 is set only in the first descriptor used for a frame.
- R6: Status bit 26 is set only in the descriptor holding the frame's last byte (`s_last`). `frame_done` pulses for one cycle after that descriptor's status write.
- R7: Every written-back status has bit 31 set and the stored byte count in bits 22:0; bits 30:28 and 25:23 are 0.
- R8: After each descriptor the current pointer takes its next pointer. If the finished descriptor was the tail, `idle` is set and fetching stops. A `tail_wr` pulse loads the tail and clears `idle`.
- R9: If the list runs out in mid-frame, `s_ready` stays low until the tail advances. The frame then continues in the next descriptor without bit 27.
- R10: A memory request holds address and direction stable until `mem_ack`. Byte writes use one strobe bit selected by address bits 1:0, and word writes use all four. An accepted data byte is followed by a byte write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Channel run enable |
| cur_load | input | 1 | Load current descriptor pointer, clear halted and idle |
| cur_in | input | AW | Current descriptor pointer value |
| tail_wr | input | 1 | Load tail pointer, clear idle |
| tail_in | input | AW | Tail descriptor pointer value |
| s_valid | input | 1 | Data byte valid |
| s_ready | output | 1 | Data byte accepted |
| s_data | input | 8 | Data byte |
| s_last | input | 1 | Last byte of frame |
| c_valid | input | 1 | Sideband word valid |
| c_ready | output | 1 | Sideband word accepted (always 1) |
| c_data | input | 32 | Sideband word |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte strobes |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read data, valid with ack |
| idle | output | 1 | Tail descriptor finished |
| halted | output | 1 | Stopped on a completed descriptor or after reset |
| frame_done | output | 1 | One-cycle pulse at frame end |

## Verification
The assertions check on every cycle the properties of the memory port and of the control outputs. A request holds still until it is acknowledged, and an accepted byte is always followed by a single-strobe write. No write happens while halted, no request is issued as idle rises, and `frame_done` comes only right after a write completes. The bench scenarios cover the things that depend on the contents of memory. These include the split of a frame across descriptor lengths, the exact status words with their frame markers, the placement of the sideband words, the stall when the list runs out in mid-frame and the resume after the tail advances, and the halt on a descriptor that is already complete.

// File: rtl/s2m_desc_writer.sv
module s2m_desc_writer #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          cur_load,
  input  logic [AW-1:0] cur_in,
  input  logic          tail_wr,
  input  logic [AW-1:0] tail_in,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  input  logic          c_valid,
  output logic          c_ready,
  input  logic [31:0]   c_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          idle,
  output logic          halted,
  output logic          frame_done
);
  localparam int LW = 23;
  localparam int NAPP = 5;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_DATA, S_WB, S_WA, S_WS, S_ADV} st_t;

  st_t           st;
  logic [AW-1:0] cur, tail, nxt, buf_a;
  logic [LW-1:0] len, cnt;
  logic [2:0]    idx, cidx;
  logic          first_q, eof_q;
  logic [7:0]    byte_q;
  logic [31:0]   app [NAPP];

  wire active = run && !idle && !halted;

  assign c_ready    = 1'b1;
  assign s_ready    = (st == S_DATA) && active && (cnt != len);
  assign mem_req    = (st == S_RD) || (st == S_WB) || (st == S_WA) || (st == S_WS);
  assign mem_we     = (st != S_RD);
  assign frame_done = (st == S_ADV) && eof_q;

  always_comb begin
    case (st)
      S_WB:    mem_addr = buf_a + AW'(cnt);
      S_WA:    mem_addr = cur + AW'(16) + (AW'(idx) << 2);
      S_WS:    mem_addr = cur + AW'(12);
      default: mem_addr = cur + (AW'(idx) << 2);
    endcase
    case (st)
      S_WB:    mem_wdata = {4{byte_q}};
      S_WA:    mem_wdata = (idx < 3'(NAPP)) ? app[idx] : 32'h0;
      default: mem_wdata = {1'b1, 3'b000, first_q, eof_q, 3'b000, cnt};
    endcase
    mem_be = (st == S_WB) ? (4'b0001 << mem_addr[1:0]) : 4'hF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cidx <= '0;
      for (int i = 0; i < NAPP; i++) app[i] <= '0;
    end else if (c_valid) begin
      app[cidx] <= c_data;
      cidx <= (cidx == 3'(NAPP - 1)) ? 3'd0 : cidx + 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cur <= '0; tail <= '0; nxt <= '0; buf_a <= '0;
      len <= '0; cnt <= '0; idx <= '0; first_q <= 1'b1; eof_q <= 1'b0;
      byte_q <= '0; idle <= 1'b0; halted <= 1'b1;
    end else begin
      case (st)
        S_IDLE: if (active) begin st <= S_RD; idx <= '0; end
        S_RD: if (mem_ack) begin
          case (idx)
            3'd0: nxt <= mem_rdata[AW-1:0];
            3'd1: buf_a <= mem_rdata[AW-1:0];
            3'd2: len <= mem_rdata[LW-1:0];
            default: ;
          endcase
          if (idx == 3'd3) begin
            cnt <= '0; eof_q <= 1'b0;
            if (mem_rdata[31]) begin halted <= 1'b1; st <= S_IDLE; end
            else st <= S_DATA;
          end else idx <= idx + 3'd1;
        end
        S_DATA:
          if (cnt == len) st <= S_WS;
          else if (s_valid && s_ready) begin
            byte_q <= s_data; eof_q <= s_last; st <= S_WB;
          end
        S_WB: if (mem_ack) begin
          cnt <= cnt + LW'(1);
          if (eof_q) begin st <= S_WA; idx <= '0; end
          else st <= S_DATA;
        end
        S_WA: if (mem_ack) begin
          if (idx == 3'(NAPP - 1)) st <= S_WS;
          else idx <= idx + 3'd1;
        end
        S_WS: if (mem_ack) st <= S_ADV;
        S_ADV: begin
          cur <= nxt;
          if (cur == tail) idle <= 1'b1;
          first_q <= eof_q;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (tail_wr) begin tail <= tail_in; idle <= 1'b0; end
      if (cur_load) begin cur <= cur_in; idle <= 1'b0; halted <= 1'b0; end
    end
  end
endmodule

module s2m_desc_writer_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_valid,
  input logic          s_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_be,
  input logic          mem_ack,
  input logic          idle,
  input logic          halted,
  input logic          frame_done
);
  a_r3_halt_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !(mem_req && mem_we));
  a_r8_idle_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> !mem_req);
  a_r6_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(mem_req && mem_we && mem_ack));
  a_r10_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  a_r10_accept_then_byte: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> mem_req && mem_we && $onehot(mem_be));
endmodule

bind s2m_desc_writer s2m_desc_writer_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
  .mem_ack(mem_ack), .idle(idle), .halted(halted), .frame_done(frame_done)
);

// File: tb/test_s2m_desc_writer.sv
module test_s2m_desc_writer;
  logic clk = 0, rst_n = 0;
  logic run = 0, cur_load = 0, tail_wr = 0;
  logic [31:0] cur_in = 0, tail_in = 0;
  logic s_valid = 0, s_last = 0, c_valid = 0;
  logic [7:0] s_data = 0;
  logic [31:0] c_data = 0;
  logic s_ready, c_ready, mem_req, mem_we, mem_ack, idle, halted, frame_done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;

  int checks = 0, errors = 0, dones = 0;
  bit finished = 0;
  logic [7:0] mem [1024];
  logic [63:0] expq [$];

  always #5 clk = ~clk;

  s2m_desc_writer i_s2m_desc_writer (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd32(int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  task automatic wr32(int a, logic [31:0] v);
    for (int i = 0; i < 4; i++) mem[a+i] = v[8*i +: 8];
  endtask

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        for (int i = 0; i < 4; i++)
          if (mem_be[i]) mem[{mem_addr[9:2], 2'(i)}] <= mem_wdata[8*i +: 8];
      end else mem_rdata <= rd32(int'({mem_addr[9:2], 2'b00}));
    end else mem_ack <= 1'b0;
  end

  always @(posedge clk) begin
    if (rst_n && frame_done) dones++;
    if (rst_n && mem_req && mem_we && mem_ack && mem_be == 4'hF && mem_addr[5:0] == 6'd12) begin
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 actual=%h expected=none", mem_wdata);
      end else begin
        logic [63:0] e;
        e = expq.pop_front();
        chk("R7 status address", mem_addr, e[63:32]);
        chk("R5 R6 R7 status word", mem_wdata, e[31:0]);
      end
    end
  end

  task automatic expect_status(logic [31:0] a, logic [31:0] s);
    expq.push_back({a, s});
  endtask

  task automatic send_byte(logic [7:0] d, logic l);
    @(negedge clk);
    s_valid = 1; s_data = d; s_last = l;
    forever begin
      if (s_ready) begin @(posedge clk); break; end
      @(negedge clk);
    end
    #1; s_valid = 0; s_last = 0;
  endtask

  task automatic send_ctl(logic [31:0] base);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); c_valid = 1; c_data = base + i;
    end
    @(negedge clk); c_valid = 0;
  endtask

  task automatic wait_stop();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (idle || halted) break;
    end
  endtask

  task automatic make_desc(int a, int nx, int bf, int ln);
    wr32(a, nx); wr32(a + 4, bf); wr32(a + 8, ln); wr32(a + 12, 0);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'hEE;
    make_desc(32'h000, 32'h040, 32'h200, 6);
    make_desc(32'h040, 32'h080, 32'h240, 4);
    make_desc(32'h080, 32'h0C0, 32'h280, 10);
    make_desc(32'h0C0, 32'h100, 32'h2C0, 8);
    make_desc(32'h100, 32'h000, 32'h300, 8);
    repeat (3) @(negedge clk);
    chk("R1 reset ready", s_ready, 0);
    chk("R1 reset halted", halted, 1);
    chk("R1 reset idle", idle, 0);
    chk("R10 reset no request", mem_req, 0);
    rst_n = 1;
    @(negedge clk);
    cur_load = 1; cur_in = 32'h000; tail_wr = 1; tail_in = 32'h080;
    @(negedge clk); cur_load = 0; tail_wr = 0;
    s_valid = 1; s_data = 8'h99;
    repeat (4) @(negedge clk);
    chk("R1 ready low while run low", s_ready, 0);
    s_valid = 0;
    chk("R2 control ready", c_ready, 1);
    send_ctl(32'h1111_0000);
    run = 1;

    // Frame A: 8 bytes over D0 (6) and D1 (2)
    expect_status(32'h00C, 32'h8800_0006);
    expect_status(32'h04C, 32'h8400_0002);
    for (int i = 0; i < 8; i++) send_byte(8'h10 + 8'(i), i == 7);
    repeat (40) @(negedge clk);
    send_ctl(32'h2222_0000);
    // Frame B: 5 bytes in D2 (len 10), tail reached
    expect_status(32'h08C, 32'h8C00_0005);
    for (int i = 0; i < 5; i++) send_byte(8'h40 + 8'(i), i == 4);
    wait_stop();
    chk("R8 idle after tail", idle, 1);
    @(negedge clk); s_valid = 1; s_data = 8'h80;
    repeat (3) @(negedge clk);
    chk("R1 ready low while idle", s_ready, 0);
    s_valid = 0;
    for (int i = 0; i < 6; i++) chk("R4 frame A D0 bytes", 32'(mem[32'h200 + i]), 32'h10 + i);
    chk("R4 frame A D1 bytes", rd32(32'h240), 32'hEEEE_1716);
    chk("R4 frame B D2 bytes", {24'h0, mem[32'h284]}, 32'h44);
    chk("R4 frame B no spill", {24'h0, mem[32'h285]}, 32'hEE);
    for (int i = 0; i < 5; i++) chk("R2 app words D1", rd32(32'h050 + 4*i), 32'h1111_0000 + i);
    for (int i = 0; i < 5; i++) chk("R2 app words D2", rd32(32'h090 + 4*i), 32'h2222_0000 + i);
    chk("R6 no app in D0", rd32(32'h010), 32'hEEEE_EEEE);
    chk("R6 two frame pulses", dones, 2);

    send_ctl(32'h3333_0000);
    @(negedge clk); tail_wr = 1; tail_in = 32'h0C0;
    @(negedge clk); tail_wr = 0;
    chk("R8 tail write clears idle", idle, 0);
    // Frame C: 12 bytes, D3 takes 8, list runs out, D4 takes 4
    expect_status(32'h0CC, 32'h8800_0008);
    expect_status(32'h10C, 32'h8400_0004);
    for (int i = 0; i < 8; i++) send_byte(8'h80 + 8'(i), 1'b0);
    wait_stop();
    chk("R9 idle mid-frame", idle, 1);
    @(negedge clk); s_valid = 1; s_data = 8'h88;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R9 ready held low mid-frame", s_ready, 0);
    end
    s_valid = 0;
    tail_wr = 1; tail_in = 32'h140;
    @(negedge clk); tail_wr = 0;
    for (int i = 8; i < 12; i++) send_byte(8'h80 + 8'(i), i == 11);
    wait_stop();
    chk("R3 halted on completed descriptor", halted, 1);
    chk("R3 idle stays low", idle, 0);
    @(negedge clk); s_valid = 1; s_data = 8'h55;
    repeat (3) @(negedge clk);
    chk("R3 ready low while halted", s_ready, 0);
    s_valid = 0;
    chk("R3 completed descriptor untouched", rd32(32'h00C), 32'h8800_0006);
    chk("R9 D3 bytes", rd32(32'h2C4), 32'h8786_8584);
    chk("R9 D4 bytes", rd32(32'h300), 32'h8B8A_8988);
    chk("R4 D4 no spill", rd32(32'h304), 32'hEEEE_EEEE);
    for (int i = 0; i < 5; i++) chk("R2 app words D4", rd32(32'h110 + 4*i), 32'h3333_0000 + i);
    chk("R6 three frame pulses", dones, 3);
    chk("R7 all writebacks seen", expq.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule